// File: doc/BRIEF.md
# Register Reservation Hazard Detector

This block tracks which architectural registers have results still pending and which have reads still pending. It checks each instruction offered for issue in an in-order pipeline against that record. Reads after writes, writes after writes and writes after reads are each reported on their own flag. Issue is held back by a combinational stall for as long as any hazard stands. The datapath, forwarding and renaming sit outside it.

A pending result register is reserved when an instruction issues. The reservation goes when the completion port names that register. Source registers are counted per reader. A register being written can therefore not be overwritten until every older reader has handed its operands back. The completion port carries the completing instruction's destination and both of its sources, each with its own valid bit. Completions in a cycle are applied before the issuing instruction is checked.

Top module: `hzd_reservation_top`

## Requirements
- R1: Out of reset no register is reserved, and a first instruction with any operands issues with `raw_o`, `waw_o`, `war_o` and `stall_o` all low.
- R2: When issue is requested, `raw_o` and `stall_o` rise in the same cycle if either valid source index names a register with an uncompleted older write.
- R3: When issue is requested, `waw_o` and `stall_o` rise in the same cycle if the valid destination names a register with an uncompleted older write.
- R4: When issue is requested, `war_o` and `stall_o` rise in the same cycle if the valid destination names a register that an older, uncompleted instruction reads.
- R5: A completion removes the reservations that it names. A completion and an issue in the same cycle are resolved with the completion applied first.
- R6: Register index 0 is never reserved and never causes a hazard, whether it is used as a source or as a destination.
- R7: An instruction that is stalled reserves nothing. Once issue is withdrawn, its registers stay free.
- R8: Read reservations are counted. A write to a register read by several older instructions keeps `war_o` high until the last of those reads completes.
- R9: While `issue_i` is low, all four outputs are low and no reservation is taken.
- R10: When a valid source register already has 2^CNT_W-2 pending reads, issue stalls with `stall_o` high and all three hazard flags low. This is 6 pending reads with the default CNT_W=3.
- R11: An instruction's own source registers never conflict with its own destination. The destination is reserved only after it issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | An instruction requests issue this cycle |
| iss_rs1_vld_i | input | 1 | First source of the issuing instruction is used |
| iss_rs1_i | input | IDX_W | First source register index |
| iss_rs2_vld_i | input | 1 | Second source is used |
| iss_rs2_i | input | IDX_W | Second source register index |
| iss_rd_vld_i | input | 1 | Issuing instruction writes a register |
| iss_rd_i | input | IDX_W | Destination register index |
| done_rd_vld_i | input | 1 | A completing instruction releases its destination |
| done_rd_i | input | IDX_W | Destination index being released |
| done_rs1_vld_i | input | 1 | A completing instruction releases its first source |
| done_rs1_i | input | IDX_W | First source index being released |
| done_rs2_vld_i | input | 1 | A completing instruction releases its second source |
| done_rs2_i | input | IDX_W | Second source index being released |
| raw_o | output | 1 | Read-after-write hazard on the offered instruction |
| waw_o | output | 1 | Write-after-write hazard |
| war_o | output | 1 | Write-after-read hazard |
| stall_o | output | 1 | Issue is held this cycle |

## Verification
The bench targets completion and issue naming the same register in the same cycle. A design that checks before it releases would stall there for a cycle it does not need. It then offers a stalled instruction and withdraws it. A design that reserves on request instead of on issue would later flag a phantom hazard. Several readers of one register are released one at a time. A design that keeps only a flag per read register would clear the write-after-read hazard too early. The bench also fills a read counter up to its headroom limit. It uses register 0 and an instruction that reads its own destination, where a naive comparator would report hazards that cannot occur.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;
  typedef enum logic [1:0] {
    HZ_RAW  = 2'd0,
    HZ_WAW  = 2'd1,
    HZ_WAR  = 2'd2,
    HZ_FULL = 2'd3
  } hz_kind_e;

  localparam int unsigned NUM_KINDS = 4;

  function automatic logic any_set(input logic [NUM_KINDS-1:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/hzd_wr_table.sv
`timescale 1ns/1ps
// One reservation bit per register for pending writes; index 0 is never held.
module hzd_wr_table #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_en_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  input  logic                clr_en_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  output logic [NUM_REGS-1:0] eff_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign eff_o[r] = 1'b0;
    end else begin : g_bit
      logic res_q, res_d, set_hit, clr_hit;
      assign set_hit = set_en_i && (set_idx_i == IDX_W'(r));
      assign clr_hit = clr_en_i && (clr_idx_i == IDX_W'(r));
      // completion applied before the issue check
      assign eff_o[r] = res_q && !clr_hit;
      assign res_d    = eff_o[r] || set_hit;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= 1'b0;
        else         res_q <= res_d;
      end
    end
  end
endmodule

// File: rtl/hzd_rd_table.sv
`timescale 1ns/1ps
// Per-register count of pending reads; two increments and two decrements per cycle.
module hzd_rd_table #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int CNT_W    = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [1:0]                       inc_en_i,
  input  logic [1:0][IDX_W-1:0]            inc_idx_i,
  input  logic [1:0]                       dec_en_i,
  input  logic [1:0][IDX_W-1:0]            dec_idx_i,
  output logic [NUM_REGS-1:0][CNT_W-1:0]   eff_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign eff_o[r] = '0;
    end else begin : g_cnt
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic [1:0]       n_inc, n_dec;
      always_comb begin
        n_inc = 2'(inc_en_i[0] && (inc_idx_i[0] == IDX_W'(r)))
              + 2'(inc_en_i[1] && (inc_idx_i[1] == IDX_W'(r)));
        n_dec = 2'(dec_en_i[0] && (dec_idx_i[0] == IDX_W'(r)))
              + 2'(dec_en_i[1] && (dec_idx_i[1] == IDX_W'(r)));
      end
      assign eff_o[r] = cnt_q - CNT_W'(n_dec);
      assign cnt_d    = eff_o[r] + CNT_W'(n_inc);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end
    end
  end
endmodule

// File: rtl/hzd_classify.sv
`timescale 1ns/1ps
module hzd_classify
  import hzd_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int CNT_W    = 3
) (
  input  logic                           issue_i,
  input  logic [1:0]                     src_vld_i,
  input  logic [1:0][IDX_W-1:0]          src_idx_i,
  input  logic                           dst_vld_i,
  input  logic [IDX_W-1:0]               dst_idx_i,
  input  logic [NUM_REGS-1:0]            wr_eff_i,
  input  logic [NUM_REGS-1:0][CNT_W-1:0] rd_eff_i,
  output logic [NUM_KINDS-1:0]           kind_o
);
  // leave room for a dual-source increment
  localparam logic [CNT_W-1:0] RD_LIMIT = CNT_W'((1 << CNT_W) - 2);

  logic [1:0] src_raw, src_full;

  for (genvar s = 0; s < 2; s++) begin : g_src
    assign src_raw[s]  = src_vld_i[s] && wr_eff_i[src_idx_i[s]];
    assign src_full[s] = src_vld_i[s] && (rd_eff_i[src_idx_i[s]] >= RD_LIMIT);
  end

  always_comb begin
    kind_o          = '0;
    kind_o[HZ_RAW]  = issue_i && (|src_raw);
    kind_o[HZ_WAW]  = issue_i && dst_vld_i && wr_eff_i[dst_idx_i];
    kind_o[HZ_WAR]  = issue_i && dst_vld_i && (rd_eff_i[dst_idx_i] != '0);
    kind_o[HZ_FULL] = issue_i && (|src_full);
  end
endmodule

// File: rtl/hzd_reservation_top.sv
`timescale 1ns/1ps
module hzd_reservation_top
  import hzd_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             iss_rs1_vld_i,
  input  logic [IDX_W-1:0] iss_rs1_i,
  input  logic             iss_rs2_vld_i,
  input  logic [IDX_W-1:0] iss_rs2_i,
  input  logic             iss_rd_vld_i,
  input  logic [IDX_W-1:0] iss_rd_i,
  input  logic             done_rd_vld_i,
  input  logic [IDX_W-1:0] done_rd_i,
  input  logic             done_rs1_vld_i,
  input  logic [IDX_W-1:0] done_rs1_i,
  input  logic             done_rs2_vld_i,
  input  logic [IDX_W-1:0] done_rs2_i,
  output logic             raw_o,
  output logic             waw_o,
  output logic             war_o,
  output logic             stall_o
);
  logic [NUM_REGS-1:0]            wr_eff;
  logic [NUM_REGS-1:0][CNT_W-1:0] rd_eff;
  logic [NUM_KINDS-1:0]           kind;
  logic                           fire;

  assign fire = issue_i && !stall_o;

  hzd_wr_table #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_wr_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (fire && iss_rd_vld_i),
    .set_idx_i(iss_rd_i),
    .clr_en_i (done_rd_vld_i),
    .clr_idx_i(done_rd_i),
    .eff_o    (wr_eff)
  );

  hzd_rd_table #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_rd_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_en_i ({fire && iss_rs2_vld_i, fire && iss_rs1_vld_i}),
    .inc_idx_i({iss_rs2_i, iss_rs1_i}),
    .dec_en_i ({done_rs2_vld_i, done_rs1_vld_i}),
    .dec_idx_i({done_rs2_i, done_rs1_i}),
    .eff_o    (rd_eff)
  );

  hzd_classify #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_classify (
    .issue_i  (issue_i),
    .src_vld_i({iss_rs2_vld_i, iss_rs1_vld_i}),
    .src_idx_i({iss_rs2_i, iss_rs1_i}),
    .dst_vld_i(iss_rd_vld_i),
    .dst_idx_i(iss_rd_i),
    .wr_eff_i (wr_eff),
    .rd_eff_i (rd_eff),
    .kind_o   (kind)
  );

  assign raw_o   = kind[HZ_RAW];
  assign waw_o   = kind[HZ_WAW];
  assign war_o   = kind[HZ_WAR];
  assign stall_o = any_set(kind);
endmodule

// File: rtl/hzd_checker.sv
`timescale 1ns/1ps
module hzd_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_i,
  input logic             iss_rs1_vld_i,
  input logic [IDX_W-1:0] iss_rs1_i,
  input logic             iss_rs2_vld_i,
  input logic [IDX_W-1:0] iss_rs2_i,
  input logic             iss_rd_vld_i,
  input logic [IDX_W-1:0] iss_rd_i,
  input logic             done_rd_vld_i,
  input logic [IDX_W-1:0] done_rd_i,
  input logic             raw_o,
  input logic             waw_o,
  input logic             war_o,
  input logic             stall_o
);
  AST_FLAG_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o || waw_o || war_o) |-> stall_o); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |-> !(raw_o || waw_o || war_o || stall_o)); // R9

  AST_ZERO_SRC_NO_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && (!iss_rs1_vld_i || iss_rs1_i == '0) && (!iss_rs2_vld_i || iss_rs2_i == '0))
    |-> !raw_o); // R6

  AST_ZERO_DST_NO_WRITE_HAZARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && iss_rd_vld_i && iss_rd_i == '0) |-> (!waw_o && !war_o)); // R6

  AST_WRITE_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !stall_o && iss_rd_vld_i && iss_rd_i != '0)
    |=> ((issue_i && iss_rd_vld_i && iss_rd_i == $past(iss_rd_i)
          && !(done_rd_vld_i && done_rd_i == $past(iss_rd_i))) -> waw_o)); // R3
endmodule

bind hzd_reservation_top hzd_checker #(.IDX_W(IDX_W)) i_hzd_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_i       (issue_i),
  .iss_rs1_vld_i (iss_rs1_vld_i),
  .iss_rs1_i     (iss_rs1_i),
  .iss_rs2_vld_i (iss_rs2_vld_i),
  .iss_rs2_i     (iss_rs2_i),
  .iss_rd_vld_i  (iss_rd_vld_i),
  .iss_rd_i      (iss_rd_i),
  .done_rd_vld_i (done_rd_vld_i),
  .done_rd_i     (done_rd_i),
  .raw_o         (raw_o),
  .waw_o         (waw_o),
  .war_o         (war_o),
  .stall_o       (stall_o)
);

// File: tb/test_hzd_reservation_top.sv
`timescale 1ns/1ps
module test_hzd_reservation_top;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue_i, iss_rs1_vld_i, iss_rs2_vld_i, iss_rd_vld_i;
  logic [IDX_W-1:0] iss_rs1_i, iss_rs2_i, iss_rd_i;
  logic done_rd_vld_i, done_rs1_vld_i, done_rs2_vld_i;
  logic [IDX_W-1:0] done_rd_i, done_rs1_i, done_rs2_i;
  logic raw_o, waw_o, war_o, stall_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  hzd_reservation_top i_hzd_reservation_top (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue_i),
    .iss_rs1_vld_i(iss_rs1_vld_i), .iss_rs1_i(iss_rs1_i),
    .iss_rs2_vld_i(iss_rs2_vld_i), .iss_rs2_i(iss_rs2_i),
    .iss_rd_vld_i(iss_rd_vld_i), .iss_rd_i(iss_rd_i),
    .done_rd_vld_i(done_rd_vld_i), .done_rd_i(done_rd_i),
    .done_rs1_vld_i(done_rs1_vld_i), .done_rs1_i(done_rs1_i),
    .done_rs2_vld_i(done_rs2_vld_i), .done_rs2_i(done_rs2_i),
    .raw_o(raw_o), .waw_o(waw_o), .war_o(war_o), .stall_o(stall_o)
  );

  task automatic clr_in();
    issue_i = 0; iss_rs1_vld_i = 0; iss_rs2_vld_i = 0; iss_rd_vld_i = 0;
    iss_rs1_i = 0; iss_rs2_i = 0; iss_rd_i = 0;
    done_rd_vld_i = 0; done_rs1_vld_i = 0; done_rs2_vld_i = 0;
    done_rd_i = 0; done_rs1_i = 0; done_rs2_i = 0;
  endtask

  task automatic do_reset();
    clr_in();
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  // offer an instruction; v = valid bit, idx = register
  task automatic offer(input logic s1v, input int s1, input logic s2v, input int s2,
                       input logic dv, input int d);
    issue_i = 1;
    iss_rs1_vld_i = s1v; iss_rs1_i = IDX_W'(s1);
    iss_rs2_vld_i = s2v; iss_rs2_i = IDX_W'(s2);
    iss_rd_vld_i  = dv;  iss_rd_i  = IDX_W'(d);
  endtask

  task automatic retire(input logic dv, input int d, input logic s1v, input int s1,
                        input logic s2v, input int s2);
    done_rd_vld_i  = dv;  done_rd_i  = IDX_W'(d);
    done_rs1_vld_i = s1v; done_rs1_i = IDX_W'(s1);
    done_rs2_vld_i = s2v; done_rs2_i = IDX_W'(s2);
  endtask

  // exp = {raw, waw, war, stall}; checked mid-cycle, then one clock is taken
  task automatic expect_cycle(input logic [3:0] exp, input string req);
    logic [3:0] act;
    #1;
    act = {raw_o, waw_o, war_o, stall_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {raw,waw,war,stall} actual=%b expected=%b", req, act, exp);
    end
    @(negedge clk);
    clr_in();
  endtask

  task automatic t_reset();
    do_reset();
    expect_cycle(4'b0000, "R9 idle after reset");
    offer(1, 1, 1, 2, 1, 3);
    expect_cycle(4'b0000, "R1 empty table");
  endtask

  task automatic t_raw_and_stall();
    do_reset();
    offer(0, 0, 0, 0, 1, 5);
    expect_cycle(4'b0000, "R2 writer issues");
    offer(1, 5, 0, 0, 1, 6);
    expect_cycle(4'b1001, "R2 rs1 reads pending write");
    offer(1, 5, 0, 0, 1, 6);
    issue_i = 0;
    expect_cycle(4'b0000, "R9 hazard fields but no issue");
    offer(0, 0, 0, 0, 1, 6);
    expect_cycle(4'b0000, "R7 stalled instruction left r6 free");
    offer(0, 0, 1, 5, 0, 0);
    expect_cycle(4'b1001, "R2 rs2 reads pending write");
  endtask

  task automatic t_waw_complete();
    do_reset();
    offer(0, 0, 0, 0, 1, 7);
    expect_cycle(4'b0000, "R3 first writer");
    offer(0, 0, 0, 0, 1, 7);
    expect_cycle(4'b0101, "R3 second writer");
    offer(0, 0, 0, 0, 1, 7);
    retire(1, 7, 0, 0, 0, 0);
    expect_cycle(4'b0000, "R5 same-cycle completion first");
    offer(1, 7, 0, 0, 0, 0);
    expect_cycle(4'b1001, "R5 reissued writer reserved again");
    retire(1, 7, 0, 0, 0, 0);
    expect_cycle(4'b0000, "R9 completion only");
    offer(1, 7, 0, 0, 0, 0);
    expect_cycle(4'b0000, "R5 completion cleared r7");
  endtask

  task automatic t_war_counted();
    do_reset();
    offer(1, 9, 1, 9, 0, 0);
    expect_cycle(4'b0000, "R8 dual reader");
    offer(1, 9, 0, 0, 0, 0);
    expect_cycle(4'b0000, "R8 reads do not block reads");
    offer(0, 0, 0, 0, 1, 9);
    expect_cycle(4'b0011, "R4 write over pending reads");
    retire(0, 0, 1, 9, 1, 9);
    expect_cycle(4'b0000, "R9 completion only");
    offer(0, 0, 0, 0, 1, 9);
    expect_cycle(4'b0011, "R8 one reader left");
    retire(0, 0, 1, 9, 0, 0);
    expect_cycle(4'b0000, "R9 completion only");
    offer(0, 0, 0, 0, 1, 9);
    expect_cycle(4'b0000, "R8 all readers gone");
  endtask

  task automatic t_reg_zero();
    do_reset();
    offer(0, 0, 0, 0, 1, 0);
    expect_cycle(4'b0000, "R6 write r0");
    offer(1, 0, 1, 0, 1, 0);
    expect_cycle(4'b0000, "R6 read and write r0 again");
    offer(1, 0, 0, 0, 1, 0);
    expect_cycle(4'b0000, "R6 r0 never reserved");
  endtask

  task automatic t_self();
    do_reset();
    offer(1, 3, 1, 3, 1, 3);
    expect_cycle(4'b0000, "R11 own source equals own dest");
    offer(1, 3, 0, 0, 0, 0);
    expect_cycle(4'b1001, "R11 dest reserved after issue");
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 0; k < 6; k++) begin
      offer(1, 12, 0, 0, 0, 0);
      expect_cycle(4'b0000, "R10 below read limit");
    end
    offer(1, 12, 0, 0, 0, 0);
    expect_cycle(4'b0001, "R10 read counter at limit");
    offer(1, 12, 0, 0, 0, 0);
    retire(0, 0, 1, 12, 0, 0);
    expect_cycle(4'b0000, "R10 completion frees headroom");
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clr_in();
    t_reset();
    t_raw_and_stall();
    t_waw_complete();
    t_war_counted();
    t_reg_zero();
    t_self();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule